// File: doc/BRIEF.md
# SD Command Token Serializer

This block assembles the 48-bit token that a host places on the command line of an SD or MMC card and sends it one bit at a time. A single-cycle request carries a 6-bit command index and a 32-bit argument. The block then drives the token out most significant bit first. It advances by one bit on each pulse of a card-clock enable that an external clock generator supplies. The 7-bit checksum is built serially, one step per outgoing payload bit, so no parallel checksum tree is needed.

The token is also available as a 48-bit parallel value and as three 16-bit words. These let neighbouring logic or a register file read the frame that was actually sent. The parallel copy keeps the last accepted command until the next request is accepted. Its checksum byte is final once busy drops.

Top module: `sd_cmd_framer`

## Requirements
- R1: The leading byte of the token (frame[47:40]) is 0x40 OR the command index, so the first two bits sent are 0 then 1.
- R2: frame[39:8] holds the argument with its most significant byte first.
- R3: The checksum is the CRC with polynomial x^7+x^3+1 over frame[47:8], processed MSB first from an all-zero value that is restored at every accepted request.
- R4: frame[7:1] is the 7-bit checksum and frame[0] is 1. Command 0 with argument 0 therefore gives a last byte of 0x95, and command 8 with argument 0x1AA gives 0x87.
- R5: While busy, cmd_out shows frame bit 47-k after k enable pulses, and it holds its value in cycles without a pulse.
- R6: busy rises in the cycle after an accepted request and falls in the cycle after the 48th enable pulse. Enable pulses while idle have no effect.
- R7: cmd_out is 1 whenever busy is 0, including after reset.
- R8: A request that arrives while busy is ignored. The token in flight, the bits sent and the parallel copy all stay those of the earlier request.
- R9: word1 = frame[15:0] (argument low byte above checksum byte), word2 = frame[31:16], word3 = frame[47:32].
- R10: After reset, busy is 0 and frame is 48'h000000000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a token, taken when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| clk_en | input | 1 | Card-clock enable, one bit per pulse |
| cmd_out | output | 1 | Serial command line |
| busy | output | 1 | Token transmission in progress |
| frame | output | 48 | Assembled token |
| word1 | output | 16 | Argument low byte and checksum byte |
| word2 | output | 16 | Argument middle bytes |
| word3 | output | 16 | Leading byte and argument high byte |

## Verification
The hardest case to reach is a second request that arrives mid-token. It must be offered during a gap between enable pulses, both while payload bits are going out and while checksum bits are going out. The directed tasks do this by holding the enable low, raising start with the inverted index and argument for one cycle, and then resuming. After that they check every remaining serial bit and the final parallel frame against the first request. Irregular enable gaps are mixed with back-to-back tokens, so both the hold behaviour and the checksum restart are exercised.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
  localparam int unsigned CRC_W_DEF = 7;
  localparam logic [CRC_W_DEF-1:0] CRC_POLY = 7'h09;
  localparam logic [1:0] LEAD_BITS = 2'b01;
endpackage

// File: rtl/sdcf_crc_serial.sv
module sdcf_crc_serial #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = din ^ crc_q[W-1];
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdcf_seq.sv
module sdcf_seq #(
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned HDR_BITS   = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          clk_en,
  output logic                          busy,
  output logic [$clog2(FRAME_BITS)-1:0] bit_cnt,
  output logic                          accept,
  output logic                          crc_step
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BITS);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    accept   = start & ~busy_q;
    step     = busy_q & clk_en;
    crc_step = step & (cnt_q < HDR_END);
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step) begin
      if (cnt_q == LAST_POS) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ARG_W  = 32,
  parameter int unsigned CRC_W  = sdcf_pkg::CRC_W_DEF,
  parameter int unsigned WORD_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [IDX_W-1:0]                       cmd_idx,
  input  logic [ARG_W-1:0]                       cmd_arg,
  input  logic                                   clk_en,
  output logic                                   cmd_out,
  output logic                                   busy,
  output logic [2+IDX_W+ARG_W+CRC_W:0]           frame,
  output logic [WORD_W-1:0]                      word1,
  output logic [WORD_W-1:0]                      word2,
  output logic [WORD_W-1:0]                      word3
);
  localparam int unsigned HDR_W     = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_W   = HDR_W + CRC_W + 1;
  localparam int unsigned NUM_WORDS = FRAME_W / WORD_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_W);
  localparam int unsigned HPOS_W    = $clog2(HDR_W);
  localparam int unsigned CPOS_W    = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] HDR_TOP  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CRC_TOP  = CNT_W'(FRAME_W - 2);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(FRAME_W - 1);

  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [CRC_W-1:0]  crc;
  logic [CNT_W-1:0]  bit_cnt;
  logic              accept, crc_step;
  logic [HPOS_W-1:0] hdr_pos;
  logic [CPOS_W-1:0] crc_pos;
  logic              hdr_bit;
  logic [WORD_W-1:0] words [NUM_WORDS];

  sdcf_seq #(
    .FRAME_BITS (FRAME_W),
    .HDR_BITS   (HDR_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .clk_en   (clk_en),
    .busy     (busy),
    .bit_cnt  (bit_cnt),
    .accept   (accept),
    .crc_step (crc_step)
  );

  sdcf_crc_serial #(
    .W    (CRC_W),
    .POLY (sdcf_pkg::CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (crc_step),
    .din   (hdr_bit),
    .crc   (crc)
  );

  always_comb begin
    hdr_d = hdr_q;
    if (accept) hdr_d = {sdcf_pkg::LEAD_BITS, cmd_idx, cmd_arg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_d;
  end

  always_comb begin
    hdr_pos = HPOS_W'(HDR_TOP - bit_cnt);
    crc_pos = CPOS_W'(CRC_TOP - bit_cnt);
    hdr_bit = hdr_q[hdr_pos];
    if (!busy)                  cmd_out = 1'b1;
    else if (bit_cnt < HDR_END) cmd_out = hdr_bit;
    else if (bit_cnt < CRC_END) cmd_out = crc[crc_pos];
    else                        cmd_out = 1'b1;
  end

  assign frame = {hdr_q, crc, 1'b1};

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign words[k] = frame[k*WORD_W +: WORD_W];
  end

  assign word1 = words[0];
  assign word2 = words[1];
  assign word3 = words[2];
endmodule

// File: rtl/sd_cmd_framer_chk.sv
module sd_cmd_framer_chk #(
  parameter int unsigned FRAME_W = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               clk_en,
  input logic               cmd_out,
  input logic               busy,
  input logic [FRAME_W-1:0] frame
);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmd_out);

  a_r1_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cmd_out);

  a_r5_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clk_en |=> busy && $stable(cmd_out));

  a_r8_header_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(frame[FRAME_W-1:8]));

  a_r4_end_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_out));

  a_r6_no_spurious_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);
endmodule

bind sd_cmd_framer sd_cmd_framer_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .clk_en  (clk_en),
  .cmd_out (cmd_out),
  .busy    (busy),
  .frame   (frame)
);

// File: tb/sd_cmd_framer_bench.sv
module sd_cmd_framer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        clk_en = 1'b0;
  logic        cmd_out, busy;
  logic [47:0] frame;
  logic [15:0] word1, word2, word3;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_framer u_sd_cmd_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .clk_en(clk_en), .cmd_out(cmd_out), .busy(busy),
    .frame(frame), .word1(word1), .word2(word2), .word3(word3)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act,
                     input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] expect_frame(input logic [5:0] idx,
                                               input logic [31:0] arg);
    logic [7:0] b [5];
    logic [7:0] acc, d;
    b[0] = 8'h40 | {2'b00, idx};
    b[1] = arg[31:24]; b[2] = arg[23:16]; b[3] = arg[15:8]; b[4] = arg[7:0];
    acc = 8'h00;
    for (int i = 0; i < 5; i++) begin
      d = b[i];
      for (int n = 0; n < 8; n++) begin
        acc = acc << 1;
        if (d[7] ^ acc[7]) acc = acc ^ 8'h09;
        d = d << 1;
      end
    end
    return {b[0], b[1], b[2], b[3], b[4], acc[6:0], 1'b1};
  endfunction

  task automatic run_frame(input logic [5:0] idx, input logic [31:0] arg,
                           input int gap, input int poke_at);
    logic [47:0] exp;
    int bit_bad, hold_bad;
    exp = expect_frame(idx, arg);
    bit_bad = 0; hold_bad = 0;
    @(negedge clk); start = 1'b1; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R6 busy after request", {47'd0, busy}, 48'd1);
    for (int i = 0; i < 48; i++) begin
      if (i == poke_at) begin
        start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1 && cmd_out === exp[47-i], "R8 request while busy",
            {46'd0, busy, cmd_out}, {46'd0, 1'b1, exp[47-i]});
      end
      if (cmd_out !== exp[47-i] && bit_bad == 0) begin
        bit_bad = 1;
        chk(1'b0, "R5 serial bit", {40'd0, 2'd0, 6'(i), cmd_out},
            {40'd0, 2'd0, 6'(i), exp[47-i]});
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (cmd_out !== exp[47-i] || busy !== 1'b1) hold_bad = 1;
      end
      clk_en = 1'b1;
      @(negedge clk); clk_en = 1'b0;
    end
    if (bit_bad == 0) chk(1'b1, "R5 serial bits", 48'd0, 48'd0);
    if (gap > 0)
      chk(hold_bad == 0, "R5 hold between pulses", 48'(hold_bad), 48'd0);
    chk(busy === 1'b0, "R6 busy drops after 48 pulses", {47'd0, busy}, 48'd0);
    chk(cmd_out === 1'b1, "R7 idle high after frame", {47'd0, cmd_out}, 48'd1);
    chk(frame[47:40] === exp[47:40], "R1 leading byte", frame, exp);
    chk(frame[39:8] === exp[39:8], "R2 argument bytes", frame, exp);
    chk(frame[7:0] === exp[7:0], "R3 checksum byte", frame, exp);
    chk({word3, word2, word1} === {exp[47:32], exp[31:16], exp[15:0]},
        "R9 register words", {word3, word2, word1}, exp);
  endtask

  task automatic test_reset;
    chk(busy === 1'b0, "R10 reset busy", {47'd0, busy}, 48'd0);
    chk(cmd_out === 1'b1, "R7 reset line high", {47'd0, cmd_out}, 48'd1);
    chk(frame === 48'h000000000001, "R10 reset frame", frame, 48'h1);
  endtask

  task automatic test_idle_pulses;
    for (int i = 0; i < 5; i++) begin
      clk_en = 1'b1; @(negedge clk);
    end
    clk_en = 1'b0;
    chk(busy === 1'b0 && cmd_out === 1'b1, "R6 idle pulses ignored",
        {46'd0, busy, cmd_out}, 48'd1);
  endtask

  task automatic test_known_vectors;
    run_frame(6'd0, 32'h0, 0, -1);
    chk(frame === 48'h400000000095, "R4 cmd0 last byte 0x95", frame,
        48'h400000000095);
    run_frame(6'd8, 32'h000001AA, 2, -1);
    chk(frame[7:0] === 8'h87, "R4 cmd8 last byte 0x87", {40'd0, frame[7:0]},
        48'h87);
  endtask

  task automatic test_busy_requests;
    run_frame(6'd17, 32'h12345678, 1, 20);
    run_frame(6'd63, 32'hFFFFFFFF, 1, 44);
    run_frame(6'd55, 32'hA5C3_0F81, 0, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_pulses();
    test_known_vectors();
    test_busy_requests();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule